// File: doc/BRIEF.md
# Sleep Request Decoder with Power-Management Control Register

This block holds a 16-bit power-management control register and a 16-bit status register behind a byte-wide write port. Software asks for a sleep state by writing the upper control byte with the sleep-enable bit set. The 3-bit sleep type in that same byte has no fixed meaning. It indexes a table of combinable action flags, and a `VARIANT` parameter chooses which table is used.

When the selected action set contains power-off, the block gives a single power-off pulse and leaves the register untouched. When it contains suspend, a small sequencer issues one-cycle strobes in a fixed order: non-volatile wake-flag write, CPU reset, peripheral/PCI reset, then cache flush. Each strobe appears only if the set selects it. The sequencer then parks in a suspended state until a resume pulse arrives. The resume sets a sticky wake bit in the status register, and software clears that bit by writing a one to it.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both registers clear to 0, all strobes go low and `suspended` goes low.
- R2: A write to address 0 stores `wr_data & 8'h07` into control bits 7:0. A write to address 1 stores `wr_data & 8'h3F` into control bits 15:8, except in the R5 case. A write to address 2 changes nothing.
- R3: A sleep request exists only for a write to address 1 with `wr_data[5]` set, which is control bit 13. The sleep type is `wr_data[4:2]`. Every other write leaves all strobes low.
- R4: Action flags are bit0 power-off, bit1 suspend, bit2 wake-flag write, bit3 CPU reset, bit4 cache flush, bit5 peripheral reset. An index that is not listed maps to 0. The tables are:
  - `VARIANT` 0: types 0..4 map to 6'h01, 6'h2E, 6'h0A, 6'h12 and 6'h02.
  - `VARIANT` 1: type 0 maps to 6'h02 and type 4 maps to 6'h01.
  - `VARIANT` 2: types 1, 2, 4, 5 and 6 map to 6'h2E, 6'h01, 6'h02, 6'h0A and 6'h2A.
- R5: For a power-off set, `power_off` is high for exactly the one cycle after the write edge. The control register keeps its old value, and the block is idle again after that cycle.
- R6: For a suspend set, strobes begin in the cycle after the write edge, one per cycle, in this order: `nv_wake_wr` if bit2 is set, `cpu_rst` if bit3 is set, `pci_rst` if bit5 is set, `cache_flush` if bit3 or bit4 is set. `suspended` follows in the next cycle.
- R7: `suspended` stays high until `resume_req` is sampled high. One cycle later `suspended` is low and status bit 15 is 1. `resume_req` has no effect when the block is not suspended.
- R8: Writes sampled while the sequencer is not idle are ignored. This covers both the strobe steps and the suspended state.
- R9: A write to address 3 with `wr_data[7]` set clears status bit 15. Writing 0 there leaves the bit unchanged. Status bits 14:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | 0/1 control low/high byte, 2/3 status low/high byte |
| wr_data | input | 8 | Write data |
| resume_req | input | 1 | Resume pulse that ends the suspended state |
| ctrl_q | output | 16 | Control register read-back |
| status_q | output | 16 | Status register read-back (bit 15 wake) |
| power_off | output | 1 | Soft power-off strobe |
| nv_wake_wr | output | 1 | Non-volatile wake-flag write strobe |
| cpu_rst | output | 1 | CPU reset strobe |
| pci_rst | output | 1 | Peripheral/PCI reset strobe (also clears gate state downstream) |
| cache_flush | output | 1 | Cache flush strobe |
| suspended | output | 1 | High while waiting for resume |

## Verification
The assertions assume that reset is held low for at least one clock before any activity. They also assume that `resume_req` is a synchronous level sampled on the clock, so a pulse lasting one or more cycles counts as a single resume once the block is suspended.

The bench changes `wr_en`, `wr_addr`, `wr_data` and `resume_req` only on falling edges. It always lets a sequence run to its end before it samples the steady state. Random writes are mixed with forced sleep requests, and the bench pulses resume only after every strobe window has closed, so no input arrives between edges.

// File: rtl/pm_sleep_pkg.sv
// Shared types and the per-variant sleep action tables.
// Assumes: action flag vectors are ACT_W bits wide with the positions below.
package pm_sleep_pkg;

    localparam int ACT_W     = 6;
    localparam int ACT_OFF   = 0;
    localparam int ACT_SUSP  = 1;
    localparam int ACT_NV    = 2;
    localparam int ACT_CPU   = 3;
    localparam int ACT_FLUSH = 4;
    localparam int ACT_PCI   = 5;
    localparam int TYPE_W    = 3;
    localparam int STEP_N    = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_NVW   = 3'd1,
        ST_CPU   = 3'd2,
        ST_PCI   = 3'd3,
        ST_FLUSH = 3'd4,
        ST_SUSP  = 3'd5,
        ST_OFF   = 3'd6
    } seq_state_e;

    // Action set for a sleep type under a given variant; unlisted types give 0.
    function automatic logic [ACT_W-1:0] sleep_actions(input int variant,
                                                       input logic [TYPE_W-1:0] typ);
        logic [ACT_W-1:0] a;
        a = '0;
        case (variant)
            0: case (typ)
                   3'd0: a = 6'h01;
                   3'd1: a = 6'h2E;
                   3'd2: a = 6'h0A;
                   3'd3: a = 6'h12;
                   3'd4: a = 6'h02;
                   default: a = '0;
               endcase
            1: case (typ)
                   3'd0: a = 6'h02;
                   3'd4: a = 6'h01;
                   default: a = '0;
               endcase
            2: case (typ)
                   3'd1: a = 6'h2E;
                   3'd2: a = 6'h01;
                   3'd4: a = 6'h02;
                   3'd5: a = 6'h0A;
                   3'd6: a = 6'h2A;
                   default: a = '0;
               endcase
            default: a = '0;
        endcase
        return a;
    endfunction

    // First pending step at or after position 'from' (0 nv,1 cpu,2 pci,3 flush), else suspend.
    function automatic seq_state_e first_step(input logic [STEP_N-1:0] pend, input int from);
        seq_state_e r;
        r = ST_SUSP;
        for (int i = STEP_N - 1; i >= 0; i--) begin
            if (i >= from && pend[i]) begin
                case (i)
                    0:       r = ST_NVW;
                    1:       r = ST_CPU;
                    2:       r = ST_PCI;
                    default: r = ST_FLUSH;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pm_sleep_decode.sv
// Recognises a sleep request on the upper control byte and looks up its action set.
// Assumes: the sleep-enable bit and type field both live in the same byte lane.
module pm_sleep_decode
    import pm_sleep_pkg::*;
#(
    parameter int VARIANT    = 0,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 2,
    parameter int SLP_EN_BIT = 13,
    parameter int TYPE_LSB   = 10
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    output logic              sleep_go,
    output logic [ACT_W-1:0]  sleep_act,
    output logic              ctrl_hold
);
    localparam int LANE    = SLP_EN_BIT / DATA_W;
    localparam int EN_POS  = SLP_EN_BIT % DATA_W;
    localparam int TY_POS  = TYPE_LSB % DATA_W;

    logic hi_wr;

    // Decode the request and its table entry.
    always_comb begin
        hi_wr     = wr_en && idle && (wr_addr == ADDR_W'(LANE));
        sleep_go  = hi_wr && wr_data[EN_POS];
        sleep_act = sleep_go ? sleep_actions(VARIANT, wr_data[TY_POS +: TYPE_W]) : '0;
        ctrl_hold = sleep_act[ACT_OFF];
    end
endmodule

// File: rtl/pm_ctrl_regs.sv
// Byte-written control register and sticky wake status register.
// Assumes: control occupies the low lanes of the address space, status the lanes above.
module pm_ctrl_regs #(
    parameter int              DATA_W    = 8,
    parameter int              ADDR_W    = 2,
    parameter int              REG_W     = 16,
    parameter logic [15:0]     CTRL_MASK = 16'h3F07,
    parameter int              WAKE_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              ctrl_hold,
    input  logic              wake_set,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  status_q
);
    localparam int NLANE     = REG_W / DATA_W;
    localparam int WAKE_ADDR = NLANE + WAKE_BIT / DATA_W;
    localparam int WAKE_POS  = WAKE_BIT % DATA_W;

    logic [REG_W-1:0]  ctrl_r;
    logic              wake_r;
    logic [NLANE-1:0]  lane_we;
    logic              wake_clr;

    // Per-lane write enables; writes only land while the sequencer is idle.
    always_comb begin
        for (int b = 0; b < NLANE; b++) begin
            lane_we[b] = wr_en && idle && !ctrl_hold && (wr_addr == ADDR_W'(b));
        end
        wake_clr = wr_en && idle && (wr_addr == ADDR_W'(WAKE_ADDR)) && wr_data[WAKE_POS];
    end

    // Control register storage, masked per lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r <= '0;
        end else begin
            for (int b = 0; b < NLANE; b++) begin
                if (lane_we[b]) begin
                    ctrl_r[b*DATA_W +: DATA_W] <= wr_data & CTRL_MASK[b*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Sticky wake bit: set on resume, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake_r <= 1'b0;
        else if (wake_set) wake_r <= 1'b1;
        else if (wake_clr) wake_r <= 1'b0;
    end

    // Read-back assembly.
    always_comb begin
        ctrl_q           = ctrl_r;
        status_q         = '0;
        status_q[WAKE_BIT] = wake_r;
    end
endmodule

// File: rtl/pm_sleep_seq.sv
// Issues the ordered one-cycle action strobes and holds the suspended state.
// Assumes: sleep_go is only raised while idle is high.
module pm_sleep_seq
    import pm_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_go,
    input  logic [ACT_W-1:0] sleep_act,
    input  logic             resume_req,
    output logic             idle,
    output logic             wake_set,
    output logic             power_off,
    output logic             nv_wake_wr,
    output logic             cpu_rst,
    output logic             pci_rst,
    output logic             cache_flush,
    output logic             suspended
);
    seq_state_e        state_q, state_d;
    logic [STEP_N-1:0] pend_q, pend_new;

    // Pending step mask from a fresh action set: nv, cpu, pci, flush.
    always_comb begin
        pend_new[0] = sleep_act[ACT_NV];
        pend_new[1] = sleep_act[ACT_CPU];
        pend_new[2] = sleep_act[ACT_PCI];
        pend_new[3] = sleep_act[ACT_CPU] | sleep_act[ACT_FLUSH];
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_go) begin
                    if (sleep_act[ACT_OFF])       state_d = ST_OFF;
                    else if (sleep_act[ACT_SUSP]) state_d = first_step(pend_new, 0);
                end
            end
            ST_NVW:   state_d = first_step(pend_q, 1);
            ST_CPU:   state_d = first_step(pend_q, 2);
            ST_PCI:   state_d = first_step(pend_q, 3);
            ST_FLUSH: state_d = ST_SUSP;
            ST_SUSP:  if (resume_req) state_d = ST_IDLE;
            ST_OFF:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and pending-mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && sleep_go) pend_q <= pend_new;
        end
    end

    // Strobes decoded from the current state.
    always_comb begin
        idle        = (state_q == ST_IDLE);
        power_off   = (state_q == ST_OFF);
        nv_wake_wr  = (state_q == ST_NVW);
        cpu_rst     = (state_q == ST_CPU);
        pci_rst     = (state_q == ST_PCI);
        cache_flush = (state_q == ST_FLUSH);
        suspended   = (state_q == ST_SUSP);
        wake_set    = suspended && resume_req;
    end
endmodule

// File: rtl/pm_sleep_ctrl.sv
// Top: control/status registers, sleep decoder and action sequencer.
// Assumes: one byte write per cycle; resume_req synchronous to clk.
module pm_sleep_ctrl
    import pm_sleep_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int REG_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              resume_req,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  status_q,
    output logic              power_off,
    output logic              nv_wake_wr,
    output logic              cpu_rst,
    output logic              pci_rst,
    output logic              cache_flush,
    output logic              suspended
);
    logic             idle;
    logic             sleep_go;
    logic [ACT_W-1:0] sleep_act;
    logic             ctrl_hold;
    logic             wake_set;

    pm_sleep_decode #(
        .VARIANT (VARIANT),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .idle      (idle),
        .sleep_go  (sleep_go),
        .sleep_act (sleep_act),
        .ctrl_hold (ctrl_hold)
    );

    pm_ctrl_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .idle      (idle),
        .ctrl_hold (ctrl_hold),
        .wake_set  (wake_set),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q)
    );

    pm_sleep_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_go    (sleep_go),
        .sleep_act   (sleep_act),
        .resume_req  (resume_req),
        .idle        (idle),
        .wake_set    (wake_set),
        .power_off   (power_off),
        .nv_wake_wr  (nv_wake_wr),
        .cpu_rst     (cpu_rst),
        .pci_rst     (pci_rst),
        .cache_flush (cache_flush),
        .suspended   (suspended)
    );
endmodule

// File: rtl/pm_sleep_chk.sv
// Temporal checks on the top-level ports, attached by bind.
// Assumes: reset is asserted at the first clock edge.
module pm_sleep_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        resume_req,
    input logic [15:0] ctrl_q,
    input logic [15:0] status_q,
    input logic        power_off,
    input logic        nv_wake_wr,
    input logic        cpu_rst,
    input logic        pci_rst,
    input logic        cache_flush,
    input logic        suspended
);
    // R6: at most one action strobe per cycle.
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({power_off, nv_wake_wr, cpu_rst, pci_rst, cache_flush, suspended}));

    // R6: wake-flag write is never preceded by a later step.
    a_r6_nv_first: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wake_wr |-> !$past(cpu_rst || pci_rst || cache_flush));

    // R6: cache flush is the last strobe before suspend.
    a_r6_flush_last: assert property (@(posedge clk) disable iff (!rst_n)
        cache_flush |=> suspended);

    // R5: power-off lasts one cycle and leaves the control register alone.
    a_r5_off_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        power_off |=> !power_off);
    a_r5_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        power_off |-> $stable(ctrl_q));

    // R7: suspended holds until a resume, which sets the wake bit.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !resume_req) |=> suspended);
    a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && resume_req) |=> (!suspended && status_q[15]));

    // R8: writes while suspended do not change the control register.
    a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> $stable(ctrl_q));

    // R2 and R9: masked and reserved bits stay zero.
    a_r2_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & 16'hC0F8) == 16'h0000);
    a_r9_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[14:0] == 15'h0);
endmodule

bind pm_sleep_ctrl pm_sleep_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .resume_req  (resume_req),
    .ctrl_q      (ctrl_q),
    .status_q    (status_q),
    .power_off   (power_off),
    .nv_wake_wr  (nv_wake_wr),
    .cpu_rst     (cpu_rst),
    .pci_rst     (pci_rst),
    .cache_flush (cache_flush),
    .suspended   (suspended)
);

// File: tb/test_pm_sleep_ctrl.sv
module test_pm_sleep_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       resume_req = 1'b0;

    logic [15:0] ctrl_o [3];
    logic [15:0] stat_o [3];
    logic [2:0]  off_o, nv_o, cpu_o, pci_o, fl_o, sus_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] exp_ctrl [3];
    logic        exp_wake [3];
    logic        exp_susp [3];

    always #2.5 clk = ~clk;

    pm_sleep_ctrl #(.VARIANT(0)) i_pm_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .resume_req(resume_req), .ctrl_q(ctrl_o[0]), .status_q(stat_o[0]),
        .power_off(off_o[0]), .nv_wake_wr(nv_o[0]), .cpu_rst(cpu_o[0]), .pci_rst(pci_o[0]),
        .cache_flush(fl_o[0]), .suspended(sus_o[0]));
    pm_sleep_ctrl #(.VARIANT(1)) i_pm_sleep_ctrl_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .resume_req(resume_req), .ctrl_q(ctrl_o[1]), .status_q(stat_o[1]),
        .power_off(off_o[1]), .nv_wake_wr(nv_o[1]), .cpu_rst(cpu_o[1]), .pci_rst(pci_o[1]),
        .cache_flush(fl_o[1]), .suspended(sus_o[1]));
    pm_sleep_ctrl #(.VARIANT(2)) i_pm_sleep_ctrl_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .resume_req(resume_req), .ctrl_q(ctrl_o[2]), .status_q(stat_o[2]),
        .power_off(off_o[2]), .nv_wake_wr(nv_o[2]), .cpu_rst(cpu_o[2]), .pci_rst(pci_o[2]),
        .cache_flush(fl_o[2]), .suspended(sus_o[2]));

    // Action table from R4.
    function automatic logic [5:0] m_act(input int v, input logic [2:0] t);
        if (v == 0) begin
            if (t == 0) return 6'h01;
            if (t == 1) return 6'h2E;
            if (t == 2) return 6'h0A;
            if (t == 3) return 6'h12;
            if (t == 4) return 6'h02;
        end else if (v == 1) begin
            if (t == 0) return 6'h02;
            if (t == 4) return 6'h01;
        end else begin
            if (t == 1) return 6'h2E;
            if (t == 2) return 6'h01;
            if (t == 4) return 6'h02;
            if (t == 5) return 6'h0A;
            if (t == 6) return 6'h2A;
        end
        return 6'h00;
    endfunction

    // Expected {off,nv,cpu,pci,flush,susp} k cycles after a sleep write edge (R5, R6).
    function automatic logic [5:0] m_obs(input logic [5:0] a, input int k);
        logic [5:0] st [4];
        int n;
        n = 0;
        if (a[0]) return (k == 1) ? 6'b100000 : 6'b000000;
        if (!a[1]) return 6'b000000;
        if (a[2])        begin st[n] = 6'b010000; n = n + 1; end
        if (a[3])        begin st[n] = 6'b001000; n = n + 1; end
        if (a[5])        begin st[n] = 6'b000100; n = n + 1; end
        if (a[3] | a[4]) begin st[n] = 6'b000010; n = n + 1; end
        if (k <= n) return st[k-1];
        return 6'b000001;
    endfunction

    function automatic logic [5:0] obs(input int v);
        return {off_o[v], nv_o[v], cpu_o[v], pci_o[v], fl_o[v], sus_o[v]};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int v = 0; v < 3; v++) begin
            check(req, $sformatf("ctrl v%0d", v), {16'h0, ctrl_o[v]}, {16'h0, exp_ctrl[v]});
            check("R9", $sformatf("status v%0d", v), {16'h0, stat_o[v]},
                  {16'h0, exp_wake[v], 15'h0});
        end
    endtask

    // One byte write, then strobe windows and register checks against the model.
    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        logic [5:0] act [3];
        logic       was_susp [3];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int v = 0; v < 3; v++) begin
            was_susp[v] = exp_susp[v];
            act[v] = (a == 2'd1 && d[5]) ? m_act(v, d[4:2]) : 6'h00;
            if (!was_susp[v]) begin
                if (a == 2'd0) exp_ctrl[v][7:0] = d & 8'h07;
                if (a == 2'd1 && !act[v][0]) exp_ctrl[v][15:8] = d & 8'h3F;
                if (a == 2'd3 && d[7]) exp_wake[v] = 1'b0;
            end
        end
        check_regs(was_susp[0] ? "R8" : "R2");
        for (int k = 1; k <= 6; k++) begin
            for (int v = 0; v < 3; v++) begin
                check(was_susp[v] ? "R8" : (a == 2'd1 && d[5]) ? "R6" : "R3",
                      $sformatf("strobes v%0d type%0d k%0d", v, d[4:2], k),
                      {26'h0, obs(v)},
                      {26'h0, was_susp[v] ? 6'b000001 : m_obs(act[v], k)});
            end
            if (k < 6) @(negedge clk);
        end
        for (int v = 0; v < 3; v++)
            if (!was_susp[v] && act[v][1] && !act[v][0]) exp_susp[v] = 1'b1;
        check_regs("R5");
    endtask

    task automatic do_resume();
        @(negedge clk);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        for (int v = 0; v < 3; v++) begin
            if (exp_susp[v]) begin exp_wake[v] = 1'b1; exp_susp[v] = 1'b0; end
            check("R7", $sformatf("suspended after resume v%0d", v), {31'h0, sus_o[v]}, 32'h0);
        end
        check_regs("R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20211018));
        for (int v = 0; v < 3; v++) begin
            exp_ctrl[v] = '0; exp_wake[v] = 1'b0; exp_susp[v] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state.
        for (int v = 0; v < 3; v++) begin
            check("R1", $sformatf("outputs in reset v%0d", v), {26'h0, obs(v)}, 32'h0);
        end
        check_regs("R1");
        rst_n = 1'b1;

        // R2: mask on both bytes; address 2 has no effect.
        do_write(2'd0, 8'hFF);
        do_write(2'd1, 8'hDF);
        do_write(2'd2, 8'hFF);

        // R4, R5, R6, R7: every sleep type under every variant.
        for (int t = 0; t < 8; t++) begin
            do_write(2'd1, 8'h20 | 8'(t << 2) | 8'hC3);
            do_resume();
            do_write(2'd3, 8'h00);   // R9: writing 0 keeps wake
            do_write(2'd3, 8'h80);   // R9: writing 1 clears wake
        end

        // R8: writes while suspended are ignored (type 4 suspends variants 0 and 2).
        do_write(2'd1, 8'h30);
        do_write(2'd0, 8'h05);
        do_write(2'd1, 8'h24);
        do_write(2'd3, 8'h80);
        do_resume();
        // R7: resume while idle has no effect.
        do_resume();
        // R1: reset mid-use clears everything.
        do_write(2'd1, 8'h24);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int v = 0; v < 3; v++) begin
            exp_ctrl[v] = '0; exp_wake[v] = 1'b0; exp_susp[v] = 1'b0;
            check("R1", $sformatf("outputs after reset v%0d", v), {26'h0, obs(v)}, 32'h0);
        end
        check_regs("R1");

        // Random mix.
        for (int i = 0; i < 300; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            if ($urandom % 3 == 0) begin a = 2'd1; d[5] = 1'b1; end
            do_write(a, d);
            if ($urandom % 2 == 0) do_resume();
        end
        do_resume();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule